// File: doc/BRIEF.md
# LIN Frame Checksum Unit

This block builds the checksum of a LIN frame one byte at a time and checks a received checksum byte against it. A start-of-frame strobe presents the protected identifier and a mode select. In enhanced mode the identifier is loaded as the first addend. In classic mode the sum starts from zero. Identifiers whose 6-bit frame ID is 0x3C or 0x3D always get classic treatment, whatever the mode select says.

Each data strobe adds one byte as an 8-bit sum. A carry out of bit 7 is folded back into bit 0. The transmit output always shows the bitwise inverse of the running sum, so after the last data byte it holds the checksum byte to send. A receiver applies the frame's checksum byte on a separate strobe. That byte is added to the sum, and the block reports a one-cycle OK or error pulse. Byte framing, serialisation and identifier parity are handled elsewhere.

Top module: `lin_cks_unit`

## Requirements
- R1: After reset, tx_chk_o is 0xFF, and chk_ok_o and chk_err_o are 0.
- R2: sof_i with enhanced mode off clears the running sum, so tx_chk_o is 0xFF in the following cycle.
- R3: sof_i with enh_i high loads pid_i as the running sum, so tx_chk_o equals the inverse of pid_i in the following cycle. This holds when the frame ID pid_i[5:0] is neither 0x3C nor 0x3D.
- R4: When pid_i[5:0] is 0x3C or 0x3D, sof_i clears the running sum even with enh_i high.
- R5: Each data_vld_i adds data_i to the running sum as a 9-bit addition. Bit 8 of that addition is then added back into the low 8 bits. tx_chk_o shows the inverse of the new sum in the cycle after the strobe.
- R6: Only the first MAX_BYTES (default 8) data strobes after sof_i are added. Later data strobes leave tx_chk_o unchanged.
- R7: A chk_vld_i adds chk_i to the running sum with carry folding. In the next cycle, chk_ok_o pulses if the result is 0xFF, and chk_err_o pulses otherwise. The two outputs are never high together.
- R8: A chk_vld_i never alters the running sum; tx_chk_o is unchanged after it.
- R9: sof_i takes priority over data_vld_i and chk_vld_i in the same cycle, and data_vld_i takes priority over chk_vld_i. A strobe that loses is ignored and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame strobe |
| pid_i | input | 8 | Protected identifier; bits 5:0 are the frame ID |
| enh_i | input | 1 | 1 selects enhanced checksum, 0 selects classic |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| chk_vld_i | input | 1 | Received checksum byte strobe |
| chk_i | input | 8 | Received checksum byte |
| tx_chk_o | output | 8 | Inverted running sum (checksum to transmit) |
| chk_ok_o | output | 1 | Pulse: received checksum matches |
| chk_err_o | output | 1 | Pulse: received checksum mismatches |

## Verification
The bench runs three kinds of frames. Short classic and enhanced frames with known byte values show whether the identifier is included and whether folding is applied. Pairs of bytes such as 0xFF followed by 0x01 produce a carry and tell end-around folding apart from a plain 8-bit wrap. Frames with IDs 0x3C, 0x3D and 0x3E separate the forced-classic decode from its neighbours. Overlong frames, colliding strobes and random frames with correct or corrupted checksums exercise the byte limit, the priority order and the compare path, with a behavioural model checked on every clock.

// File: rtl/lin_cks_pkg.sv
package lin_cks_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // 8-bit add, carry out of bit 7 added back into bit 0
  function automatic byte_t fold_add(input byte_t a, input byte_t b);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
  endfunction
endpackage

// File: rtl/lin_cks_mode.sv
module lin_cks_mode
  import lin_cks_pkg::*;
#(
  parameter int unsigned ID_W    = 6,
  parameter logic [5:0]  DIAG_LO = 6'h3C,
  parameter logic [5:0]  DIAG_HI = 6'h3D
) (
  input  byte_t pid_i,
  input  logic  enh_i,
  output logic  enh_eff_o
);
  logic [ID_W-1:0] frame_id;
  logic            force_classic;

  assign frame_id      = pid_i[ID_W-1:0];
  assign force_classic = (frame_id == DIAG_LO[ID_W-1:0]) || (frame_id == DIAG_HI[ID_W-1:0]);
  assign enh_eff_o     = enh_i && !force_classic;
endmodule

// File: rtl/lin_cks_acc.sv
module lin_cks_acc
  import lin_cks_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sof_i,
  input  byte_t pid_i,
  input  logic  enh_eff_i,
  input  logic  data_vld_i,
  input  byte_t data_i,
  output byte_t acc_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

  byte_t            acc_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (sof_i) begin
      acc_q <= enh_eff_i ? pid_i : '0;
      cnt_q <= '0;
    end else if (data_vld_i && (cnt_q < MAX_CNT)) begin
      acc_q <= fold_add(acc_q, data_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign acc_o = acc_q;

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_CNT);

  a_r6_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_i && cnt_q == MAX_CNT) |=> $stable(acc_q));
endmodule

// File: rtl/lin_cks_cmp.sv
module lin_cks_cmp
  import lin_cks_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  chk_take_i,
  input  byte_t acc_i,
  input  byte_t chk_i,
  output logic  ok_o,
  output logic  err_o
);
  logic match;
  assign match = (fold_add(acc_i, chk_i) == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      ok_o  <= chk_take_i && match;
      err_o <= chk_take_i && !match;
    end
  end

  a_r7_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, err_o}));

  a_r7_take_reports: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take_i |=> (ok_o || err_o));
endmodule

// File: rtl/lin_cks_unit.sv
module lin_cks_unit
  import lin_cks_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8,
  parameter int unsigned ID_W      = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sof_i,
  input  logic [7:0] pid_i,
  input  logic       enh_i,
  input  logic       data_vld_i,
  input  logic [7:0] data_i,
  input  logic       chk_vld_i,
  input  logic [7:0] chk_i,
  output logic [7:0] tx_chk_o,
  output logic       chk_ok_o,
  output logic       chk_err_o
);
  logic  enh_eff;
  logic  chk_take;
  byte_t acc;

  assign chk_take = chk_vld_i && !sof_i && !data_vld_i;

  lin_cks_mode #(.ID_W(ID_W)) u_mode (
    .pid_i     (pid_i),
    .enh_i     (enh_i),
    .enh_eff_o (enh_eff)
  );

  lin_cks_acc #(.MAX_BYTES(MAX_BYTES)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .pid_i      (pid_i),
    .enh_eff_i  (enh_eff),
    .data_vld_i (data_vld_i),
    .data_i     (data_i),
    .acc_o      (acc)
  );

  lin_cks_cmp u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chk_take_i (chk_take),
    .acc_i      (acc),
    .chk_i      (chk_i),
    .ok_o       (chk_ok_o),
    .err_o      (chk_err_o)
  );

  assign tx_chk_o = ~acc;

  a_r2_classic_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !enh_i) |=> (tx_chk_o == 8'hFF));

  a_r4_diag_classic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && (pid_i[5:0] == 6'h3C || pid_i[5:0] == 6'h3D)) |=> (tx_chk_o == 8'hFF));

  a_r8_chk_keeps_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_vld_i && !sof_i && !data_vld_i) |=> $stable(tx_chk_o));

  a_r9_no_pulse_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i || data_vld_i) |=> !(chk_ok_o || chk_err_o));
endmodule

// File: tb/lin_cks_unit_bench.sv
`timescale 1ns/1ps
module lin_cks_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, enh = 1'b0, dv = 1'b0, cv = 1'b0;
  logic [7:0] pid = '0, d = '0, c = '0;
  logic [7:0] tx;
  logic       ok, err;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";

  int m_acc = 0, m_cnt = 0;
  bit m_ok = 0, m_err = 0;

  always #4 clk = ~clk;

  lin_cks_unit u_lin_cks_unit (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .pid_i(pid), .enh_i(enh),
    .data_vld_i(dv), .data_i(d), .chk_vld_i(cv), .chk_i(c),
    .tx_chk_o(tx), .chk_ok_o(ok), .chk_err_o(err)
  );

  function automatic int fadd(int a, int b);
    int s;
    s = a + b;
    if (s > 255) s = s - 255;
    return s;
  endfunction

  // behavioural reference, updated on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_ok = 0; m_err = 0;
    end else if (sof) begin
      m_acc = (enh && pid[5:0] != 6'h3C && pid[5:0] != 6'h3D) ? int'(pid) : 0;
      m_cnt = 0; m_ok = 0; m_err = 0;
    end else if (dv) begin
      if (m_cnt < 8) begin
        m_acc = fadd(m_acc, int'(d));
        m_cnt++;
      end
      m_ok = 0; m_err = 0;
    end else if (cv) begin
      m_ok  = (fadd(m_acc, int'(c)) == 255);
      m_err = !m_ok;
    end else begin
      m_ok = 0; m_err = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (tx !== 8'(255 - m_acc) || ok !== m_ok || err !== m_err) begin
        n_errors++;
        $display("FAIL %s model: tx=%h ok=%b err=%b expected tx=%h ok=%b err=%b",
                 cur_req, tx, ok, err, 8'(255 - m_acc), m_ok, m_err);
      end
    end
  end

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit s, logic [7:0] p, bit e, bit v, logic [7:0] dd, bit k, logic [7:0] cc);
    sof = s; pid = p; enh = e; dv = v; d = dd; cv = k; c = cc;
    @(posedge clk); #1;
    sof = 0; dv = 0; cv = 0;
  endtask

  task automatic start(logic [7:0] p, bit e);
    step(1, p, e, 0, 0, 0, 0);
  endtask
  task automatic byte_in(logic [7:0] b);
    step(0, 0, 0, 1, b, 0, 0);
  endtask
  task automatic chk_in(logic [7:0] b);
    step(0, 0, 0, 0, 0, 1, b);
  endtask

  initial begin
    #1000000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check8("R1 reset tx", tx, 8'hFF);
    check8("R1 reset pulses", {6'b0, ok, err}, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;

    cur_req = "R2";
    start(8'h11, 0);
    check8("R2 classic clear", tx, 8'hFF);
    cur_req = "R5";
    byte_in(8'h4A); byte_in(8'h55); byte_in(8'h93); byte_in(8'hE5);
    check8("R5 classic frame", tx, 8'hE6);
    cur_req = "R7";
    chk_in(8'hE6);
    check8("R7 ok pulse", {6'b0, ok, err}, 8'h02);
    cur_req = "R8";
    check8("R8 sum kept", tx, 8'hE6);
    cur_req = "R7";
    chk_in(8'hE7);
    check8("R7 err pulse", {6'b0, ok, err}, 8'h01);

    cur_req = "R3";
    start(8'h80, 1);
    check8("R3 enhanced pid load", tx, 8'h7F);
    cur_req = "R4";
    start(8'hBC, 1);
    check8("R4 id 0x3C classic", tx, 8'hFF);
    start(8'h7D, 1);
    check8("R4 id 0x3D classic", tx, 8'hFF);
    cur_req = "R3";
    start(8'h3E, 1);
    check8("R3 id 0x3E enhanced", tx, 8'hC1);

    cur_req = "R5";
    start(8'h00, 0);
    byte_in(8'hFF); byte_in(8'h01);
    check8("R5 carry fold", tx, 8'hFE);

    cur_req = "R6";
    start(8'h00, 0);
    for (int i = 0; i < 8; i++) byte_in(8'h01);
    byte_in(8'h55); byte_in(8'h55);
    check8("R6 bytes beyond limit ignored", tx, 8'hF7);

    cur_req = "R9";
    start(8'h00, 0);
    byte_in(8'h10);
    step(1, 8'h80, 1, 1, 8'h22, 1, 8'h00);
    check8("R9 sof wins", tx, 8'h7F);
    step(0, 0, 0, 1, 8'h01, 1, 8'h7E);
    check8("R9 data wins sum", tx, 8'h7E);
    check8("R9 check ignored", {6'b0, ok, err}, 8'h00);

    cur_req = "R7";
    for (int f = 0; f < 60; f++) begin
      int nb;
      logic [7:0] pp;
      nb = $urandom_range(0, 8);
      pp = 8'($urandom);
      start(pp, bit'($urandom_range(0, 1)));
      for (int b = 0; b < nb; b++) byte_in(8'($urandom));
      if ($urandom_range(0, 1) == 1) chk_in(tx);
      else chk_in(tx ^ 8'h01);
      @(posedge clk); #1;
    end

    @(posedge clk); #1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule